// File: doc/BRIEF.md
# Character Output Control and Status Register

This block is the command-facing register of a character printer channel. A processor issues device commands as a strobe with a 6-bit device select, a 3-bit function code and the 12-bit accumulator. When the device select matches the block's own address, the function code decides how the command acts on the block. A command can set or clear the output-ready flag, test the flags and raise a skip, or latch a character for transmission. One command does both the clear and the latch. An input-ready flag, set by the receive side through a plain pin, can be tested together with the output flag.

A latched character leaves on a valid/ready stream toward the serializer. `tx_valid` rises on the edge after a load command. A transfer happens on any edge where `tx_valid` and `tx_ready` are both high. While the sink holds `tx_ready` low, `tx_valid` stays high and `tx_data` does not change, unless a new load command replaces the waiting character. A load in the same cycle as a transfer leaves a fresh character pending. The serializer reports the end of a character on `tx_done`, and that sets the output-ready flag.

Top module: `char_out_ctrl`

## Requirements
- R1: After reset, the output flag, its shadow, the input flag, `tx_valid`, `tx_data`, `skip` and `illegal_cmd` are all 0.
- R2: Function code 0 sets the output flag and its shadow on the clock edge that samples the strobe.
- R3: Function code 1 drives `skip` to the output flag's value, combinationally, while the strobe is high. `skip` is 0 whenever the strobe is low.
- R4: Function code 2 clears the output flag and its shadow on the strobed edge.
- R5: Function code 4 makes `tx_data` equal to accumulator bits 7:0 with bit 7 inverted, and raises `tx_valid`, on the strobed edge. It leaves all flags unchanged.
- R6: Function code 5 drives `skip` high when the output flag or the input flag is set.
- R7: Function code 6 clears the output flag and its shadow, and also loads `tx_data` and raises `tx_valid` as in R5, on the same edge.
- R8: A strobed command with function code 3 or 7, or with a device select other than 4, drives `illegal_cmd` high during the strobe. It drives `skip` low and changes no flag or stream state.
- R9: When `tx_valid` is high and `tx_ready` is low, and no load command arrives, `tx_valid` stays high and `tx_data` stays stable. When both are high, `tx_valid` drops on that edge unless a load command arrives on the same edge.
- R10: `tx_done` sets the output flag but not its shadow. A same-edge command of function code 0, 2 or 6 takes priority over it.
- R11: A pulse on `rx_set` sets the input flag, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_strobe | input | 1 | Command present this cycle |
| cmd_dev | input | 6 | Device select of the command |
| cmd_fn | input | 3 | Function code of the command |
| acc | input | 12 | Accumulator value that comes with the command |
| skip | output | 1 | Tested condition holds (combinational) |
| illegal_cmd | output | 1 | Strobed command is not legal (combinational) |
| tx_done | input | 1 | Serializer finished a character |
| rx_set | input | 1 | Receive side has a character ready |
| tx_valid | output | 1 | Stream: character pending |
| tx_ready | input | 1 | Stream: sink accepts the character |
| tx_data | output | 8 | Stream: pending character |
| out_flag | output | 1 | Output-ready flag |
| out_shadow | output | 1 | Shadow copy of the output flag, written only by commands |
| in_flag | output | 1 | Input-ready flag |

## Verification
The command decoder is swept over every pair of device select and function code. Each pair is tried from all four starting combinations of output flag and input flag, with an accumulator value computed from the case indices. This shows that a skip follows only the flags its function code names, and that a mismatched device can never pass as device 4. Directed sequences then exercise the stream. They stall `tx_ready` across several cycles, drain the character, and overlap a load with a transfer. Further sequences pit `tx_done` against a clearing command on the same edge, and check that the input flag stays set.

// File: rtl/char_out_pkg.sv
package char_out_pkg;
  typedef enum logic [2:0] {
    FN_SET_RDY   = 3'd0,
    FN_TEST_RDY  = 3'd1,
    FN_CLR_RDY   = 3'd2,
    FN_RSVD3     = 3'd3,
    FN_LOAD      = 3'd4,
    FN_TEST_ANY  = 3'd5,
    FN_CLR_LOAD  = 3'd6,
    FN_RSVD7     = 3'd7
  } fn_e;

  typedef struct packed {
    logic set_rdy;
    logic clr_rdy;
    logic load;
    logic test_rdy;
    logic test_any;
    logic illegal;
  } op_t;
endpackage

// File: rtl/char_out_decode.sv
module char_out_decode
  import char_out_pkg::*;
#(
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] DEV_SEL = 6'o04
) (
  input  logic             strobe,
  input  logic [DEV_W-1:0] dev,
  input  logic [2:0]       fn,
  output op_t              op
);
  fn_e fn_v;
  logic hit;

  assign fn_v = fn_e'(fn);
  assign hit  = strobe && (dev == DEV_SEL);

  always_comb begin
    op = '0;
    if (strobe && !hit) begin
      op.illegal = 1'b1;
    end else if (hit) begin
      unique case (fn_v)
        FN_SET_RDY:  op.set_rdy  = 1'b1;
        FN_TEST_RDY: op.test_rdy = 1'b1;
        FN_CLR_RDY:  op.clr_rdy  = 1'b1;
        FN_LOAD:     op.load     = 1'b1;
        FN_TEST_ANY: op.test_any = 1'b1;
        FN_CLR_LOAD: begin
          op.clr_rdy = 1'b1;
          op.load    = 1'b1;
        end
        FN_RSVD3, FN_RSVD7: op.illegal = 1'b1;
        default: op.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/char_out_flags.sv
module char_out_flags
  import char_out_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_t  op,
  input  logic tx_done,
  input  logic rx_set,
  output logic out_flag,
  output logic out_shadow,
  output logic in_flag,
  output logic skip
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_flag   <= 1'b0;
      out_shadow <= 1'b0;
      in_flag    <= 1'b0;
    end else begin
      if (op.clr_rdy) begin
        out_flag   <= 1'b0;
        out_shadow <= 1'b0;
      end else if (op.set_rdy) begin
        out_flag   <= 1'b1;
        out_shadow <= 1'b1;
      end else if (tx_done) begin
        out_flag <= 1'b1;
      end
      if (rx_set) in_flag <= 1'b1;
    end
  end

  assign skip = (op.test_rdy && out_flag) || (op.test_any && (out_flag || in_flag));

  a_r2_set_both: assert property (@(posedge clk) disable iff (!rst_n)
    op.set_rdy |=> (out_flag && out_shadow));
  a_r4_clr_both: assert property (@(posedge clk) disable iff (!rst_n)
    op.clr_rdy |=> (!out_flag && !out_shadow));
  a_r10_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !op.clr_rdy && !op.set_rdy) |=> (out_flag && $stable(out_shadow)));
  a_r11_in_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    in_flag |=> in_flag);
endmodule

// File: rtl/char_out_txhold.sv
module char_out_txhold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data
);
  localparam logic [CHAR_W-1:0] TOP_FLIP = {1'b1, {(CHAR_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= char_in ^ TOP_FLIP;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !load) |=> (tx_valid && $stable(tx_data)));
  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !load) |=> !tx_valid);
  a_r5_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tx_valid);
endmodule

// File: rtl/char_out_ctrl.sv
module char_out_ctrl
  import char_out_pkg::*;
#(
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] DEV_SEL = 6'o04,
  parameter int ACC_W = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_strobe,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic [2:0]        cmd_fn,
  input  logic [ACC_W-1:0]  acc,
  output logic              skip,
  output logic              illegal_cmd,
  input  logic              tx_done,
  input  logic              rx_set,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  output logic              out_flag,
  output logic              out_shadow,
  output logic              in_flag
);
  op_t op;
  logic unused_acc_hi;

  assign unused_acc_hi = ^acc[ACC_W-1:CHAR_W];

  char_out_decode #(.DEV_W(DEV_W), .DEV_SEL(DEV_SEL)) u_dec (
    .strobe(cmd_strobe), .dev(cmd_dev), .fn(cmd_fn), .op(op)
  );

  char_out_flags u_flags (
    .clk(clk), .rst_n(rst_n), .op(op), .tx_done(tx_done), .rx_set(rx_set),
    .out_flag(out_flag), .out_shadow(out_shadow), .in_flag(in_flag), .skip(skip)
  );

  char_out_txhold #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(op.load), .char_in(acc[CHAR_W-1:0]),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign illegal_cmd = op.illegal;

  a_r3_skip_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> cmd_strobe);
  a_r8_illegal_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> !skip);
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_cmd && !tx_done && !rx_set && !tx_ready) |=>
      ($stable(out_flag) && $stable(out_shadow) && $stable(tx_valid) && $stable(tx_data)));
endmodule

// File: tb/tb_char_out_ctrl.sv
`timescale 1ns/1ps
module tb_char_out_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_strobe = 1'b0;
  logic [5:0] cmd_dev = '0;
  logic [2:0] cmd_fn = '0;
  logic [11:0] acc = '0;
  logic skip, illegal_cmd, tx_valid, out_flag, out_shadow, in_flag;
  logic tx_done = 1'b0, rx_set = 1'b0, tx_ready = 1'b0;
  logic [7:0] tx_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  char_out_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_dev(cmd_dev),
    .cmd_fn(cmd_fn), .acc(acc), .skip(skip), .illegal_cmd(illegal_cmd),
    .tx_done(tx_done), .rx_set(rx_set), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .out_flag(out_flag), .out_shadow(out_shadow), .in_flag(in_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_strobe = 0; tx_done = 0; rx_set = 0; tx_ready = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive a command at a negedge, hold through one posedge, release at the next negedge
  task automatic cmd(input logic [5:0] d, input logic [2:0] f, input logic [11:0] a);
    cmd_strobe = 1; cmd_dev = d; cmd_fn = f; acc = a;
    @(negedge clk);
    cmd_strobe = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk({out_flag, out_shadow, in_flag, tx_valid} == 0 && tx_data == 0 && !skip && !illegal_cmd,
        "R1 reset state", {out_flag, out_shadow, in_flag, tx_valid}, 0);

    // sweep: every device x function code x starting flag combination
    for (int d = 0; d < 64; d++) begin
      for (int f = 0; f < 8; f++) begin
        for (int s = 0; s < 4; s++) begin
          automatic int a = (d * 53 + f * 419 + s * 1111) % 4096;
          automatic bit of = s[0];
          automatic bit inf = s[1];
          automatic bit legal = (d == 4) && (f != 3) && (f != 7);
          automatic bit e_skip, e_of, e_sh, e_v;
          automatic int e_data;
          do_reset();
          if (of) cmd(6'o04, 3'd0, 12'h000);
          if (inf) begin rx_set = 1; @(negedge clk); rx_set = 0; end
          e_skip = legal && ((f == 1 && of) || (f == 5 && (of || inf)));
          e_of = of; e_sh = of; e_v = 0; e_data = 0;
          if (legal) begin
            if (f == 0) begin e_of = 1; e_sh = 1; end
            if (f == 2 || f == 6) begin e_of = 0; e_sh = 0; end
            if (f == 4 || f == 6) begin e_v = 1; e_data = (a & 8'hFF) ^ 8'h80; end
          end
          cmd_strobe = 1; cmd_dev = 6'(d); cmd_fn = 3'(f); acc = 12'(a);
          #1;
          chk(skip == e_skip, (f == 5) ? "R6 skip any" : "R3 skip rdy", skip, e_skip);
          chk(illegal_cmd == !legal, "R8 illegal flag", illegal_cmd, !legal);
          @(negedge clk);
          cmd_strobe = 0;
          #1;
          chk(out_flag == e_of && out_shadow == e_sh,
              (f == 0) ? "R2 set" : (f == 2 || f == 6) ? "R4 R7 clear" : "R8 flags kept",
              {out_flag, out_shadow}, {e_of, e_sh});
          chk(tx_valid == e_v && tx_data == e_data,
              (f == 6) ? "R7 clear+load" : "R5 load data", tx_data, e_data);
          chk(in_flag == inf, "R11 in flag", in_flag, inf);
        end
      end
    end

    // R3: strobe low -> no skip even with flag set
    do_reset();
    cmd(6'o04, 3'd0, 0);
    cmd_dev = 6'o04; cmd_fn = 3'd1; #1;
    chk(skip == 0, "R3 no strobe no skip", skip, 0);

    // R9 stall then drain
    do_reset();
    cmd(6'o04, 3'd4, 12'hF41);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(tx_valid == 1 && tx_data == 8'hC1, "R9 stall hold", tx_data, 8'hC1);
    end
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    chk(tx_valid == 0, "R9 drain", tx_valid, 0);
    chk(tx_data == 8'hC1, "R9 data after drain", tx_data, 8'hC1);

    // R9 load on the same edge as a transfer
    cmd(6'o04, 3'd4, 12'h012);
    tx_ready = 1;
    cmd(6'o04, 3'd6, 12'h1FF);
    tx_ready = 0;
    chk(tx_valid == 1 && tx_data == 8'h7F, "R9 load overlaps transfer", tx_data, 8'h7F);

    // R10 done sets flag only
    do_reset();
    tx_done = 1; @(negedge clk); tx_done = 0;
    chk(out_flag == 1 && out_shadow == 0, "R10 done sets flag", {out_flag, out_shadow}, 2);
    cmd_strobe = 1; cmd_dev = 6'o04; cmd_fn = 3'd1; #1;
    chk(skip == 1, "R10 R3 skip after done", skip, 1);
    @(negedge clk); cmd_strobe = 0;

    // R10 clear wins over same-edge done
    cmd(6'o04, 3'd0, 0);
    tx_done = 1;
    cmd(6'o04, 3'd2, 0);
    tx_done = 0;
    chk(out_flag == 0 && out_shadow == 0, "R10 clear beats done", out_flag, 0);

    // R11 sticky input flag
    rx_set = 1; @(negedge clk); rx_set = 0;
    cmd(6'o04, 3'd2, 0);
    cmd(6'o04, 3'd6, 0);
    repeat (3) @(negedge clk);
    chk(in_flag == 1, "R11 in flag sticky", in_flag, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule